// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt and Flag Unit

This block is the interrupt and rate section of a PC-style real-time clock. It runs on the system clock and counts enable pulses on `tick_i`, which mark a 32.768 kHz time base. A 15-bit divider chain turns those pulses into three things:

- a periodic event at a rate chosen by a four-bit code,
- a square wave that toggles on every periodic event,
- a once-per-second update start pulse for the calendar logic, with an update-in-progress indication around it.

Three interrupt sources set sticky flags:

- the periodic event,
- an external alarm-match pulse,
- an external update-finished pulse.

A summary bit collects every flag whose source is enabled, and drives the interrupt request. Software reaches three 8-bit registers through a small port. The control register holds the update-in-progress bit, the divider mode and the rate code. The enable register holds the source enables, square-wave enable and update inhibit. The status register holds the flags and is cleared by reading it.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, all three registers read 0x00 and `irq_o`, `sqw_o`, `per_tick_o` and `upd_start_o` are low.
- R2: `addr_i` selects the register: 0 is the control register, 1 is the enable register, 2 is the status register, and 3 reads 0x00. A write to address 0 stores bits 6:0; bit 7 is read-only. A write to address 1 stores all 8 bits. A write to address 2 changes nothing. Write data becomes readable in the cycle after the write edge.
- R3: Control bits 3:0 hold the rate code c. For c from 1 to 15, a periodic event occurs every 2^(c-1) counted ticks, on the tick where the divider's low c-1 bits are all ones. Code 1 fires on every tick and code 3 fires every 4 ticks. Code 0 gives no events. `per_tick_o` pulses for one cycle after the clock edge that counted the event.
- R4: Status bit 6 is set by a periodic event. Status bit 5 is set by a pulse on `alarm_i`. Status bit 4 is set by a pulse on `upd_done_i`. Each becomes visible one cycle after its cause.
- R5: A read of address 2 (`rd_i` high) returns the current status. At that clock edge, bits 7:4 are cleared. An event arriving in that same cycle is kept and shows on the next read.
- R6: Status bit 7 is set when any of bits 6, 5 or 4 is set while its enable is set. The enables are bit 6, bit 5 and bit 4 of the enable register, in that order. Bit 7 stays set until the status register is read. `irq_o` equals status bit 7.
- R7: Enable-register bit 3 turns on the square wave. `sqw_o` toggles on each periodic event. It is forced low while bit 3 is clear, while the rate code is 0, or while the divider is held in reset.
- R8: Control bits 6:4 select the divider mode. Value 010 counts ticks. Values 110 and 111 hold the divider at zero, so no periodic or update events occur. Any other value freezes the divider.
- R9: `upd_start_o` pulses each time the divider wraps, which is every 32768 ticks. The first pulse comes exactly 32768 ticks after the divider leaves reset. While enable-register bit 7 is set, no pulse is produced.
- R10: Control bit 7 is the update-in-progress bit. It rises 8 ticks before an update pulse, and only when bit 7 of the enable register is clear. It falls on `upd_done_i` or when the divider is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per time-base period |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (clears status when address is 2) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register, combinational |
| alarm_i | input | 1 | Alarm-match pulse |
| upd_done_i | input | 1 | Update-finished pulse |
| irq_o | output | 1 | Interrupt request, active high |
| sqw_o | output | 1 | Square-wave output |
| per_tick_o | output | 1 | Periodic event pulse |
| upd_start_o | output | 1 | Once-per-second update start pulse |

## Verification
Read data is combinational, so it is due in the same cycle as the address. Register writes, flags, the summary bit and `irq_o` show one clock after the edge that saw the write, the tick or the pulse. `per_tick_o`, `upd_start_o` and the square-wave toggle also follow that counting edge by one clock. The first update pulse is due on the 32768th counted tick after the divider leaves reset, and the update-in-progress bit rises 8 ticks before it.

The bench drives every input on the falling edge and samples 2 ns later. Its behavioural model is stepped on the rising edge from the pre-edge inputs. Each output is therefore compared against the value that is due in exactly that cycle.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned RATE_W = 4;
  localparam int unsigned REG_W  = 8;
  localparam logic [2:0]  DV_RUN = 3'b010;

  typedef enum logic [1:0] {
    ADDR_CTL  = 2'd0,
    ADDR_ENA  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } rtc_addr_e;

  typedef struct packed {
    logic inhibit;
    logic pie;
    logic aie;
    logic uie;
    logic sqwe;
    logic [2:0] spare;
  } ena_reg_t;

  typedef struct packed {
    logic pf;
    logic af;
    logic uf;
  } flags_t;
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int unsigned DIV_W    = 15,
  parameter int unsigned RATE_W   = 4,
  parameter int unsigned UIP_LEAD = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              hold_i,
  input  logic              inhibit_i,
  input  logic              done_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              per_evt_o,
  output logic              upd_evt_o,
  output logic              uip_o,
  output logic [DIV_W-1:0]  cnt_o
);
  localparam int unsigned    TAP_N  = 1 << RATE_W;
  localparam logic [DIV_W-1:0] UIP_AT = {DIV_W{1'b1}} - DIV_W'(UIP_LEAD);

  logic [DIV_W-1:0] cnt_q;
  logic [TAP_N-1:0] tap;
  logic             step;
  logic             uip_set;
  logic             uip_q;

  // tap[k]: the low k divider bits are all ones; the top entry is unused (code 0)
  for (genvar k = 0; k < TAP_N; k++) begin : g_tap
    if (k == 0) begin : g_first
      assign tap[k] = 1'b1;
    end else if (k == TAP_N - 1) begin : g_last
      assign tap[k] = 1'b0;
    end else begin : g_mid
      assign tap[k] = &cnt_q[k-1:0];
    end
  end

  assign step      = tick_i & run_i & ~hold_i;
  assign per_evt_o = step & (rate_i != '0) & tap[rate_i - RATE_W'(1)];
  assign upd_evt_o = step & (&cnt_q) & ~inhibit_i;
  assign uip_set   = step & (cnt_q == UIP_AT) & ~inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               uip_q <= 1'b0;
    else if (uip_set)          uip_q <= 1'b1;
    else if (done_i || hold_i) uip_q <= 1'b0;
  end

  assign uip_o = uip_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags
  import rtc_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  flags_t set_i,
  input  flags_t en_i,
  input  logic   clr_i,
  output flags_t flags_o,
  output logic   irqf_o
);
  flags_t fl_q, fl_d;
  logic   irqf_q, irqf_d;

  // events in the clearing cycle survive into the new value
  always_comb begin
    fl_d   = clr_i ? set_i : (fl_q | set_i);
    irqf_d = (irqf_q & ~clr_i) | (|(fl_d & en_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q   <= '0;
      irqf_q <= 1'b0;
    end else begin
      fl_q   <= fl_d;
      irqf_q <= irqf_d;
    end
  end

  assign flags_o = fl_q;
  assign irqf_o  = irqf_q;
endmodule

// File: rtl/rtc_sqw.sv
module rtc_sqw (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic toggle_i,
  output logic sqw_o
);
  logic sqw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sqw_q <= 1'b0;
    else if (!en_i)    sqw_q <= 1'b0;
    else if (toggle_i) sqw_q <= ~sqw_q;
  end

  assign sqw_o = sqw_q;
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DIV_W    = 15,
  parameter int unsigned UIP_LEAD = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       alarm_i,
  input  logic       upd_done_i,
  output logic       irq_o,
  output logic       sqw_o,
  output logic       per_tick_o,
  output logic       upd_start_o
);
  rtc_addr_e         addr;
  logic [2:0]        dv_q;
  logic [RATE_W-1:0] rate_q;
  ena_reg_t          ena_q;
  logic              run, hold, rd_c;
  logic              per_evt, upd_evt, uip;
  logic [DIV_W-1:0]  cnt;
  flags_t            flags, fl_set, fl_en;
  logic              irqf;
  logic              per_q, upd_q;

  assign addr = rtc_addr_e'(addr_i);
  assign run  = (dv_q == DV_RUN);
  assign hold = (dv_q[2:1] == 2'b11);
  assign rd_c = rd_i & (addr == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q   <= '0;
      rate_q <= '0;
      ena_q  <= '0;
    end else if (wr_i) begin
      case (addr)
        ADDR_CTL: {dv_q, rate_q} <= wdata_i[6:0];
        ADDR_ENA: ena_q <= ena_reg_t'(wdata_i);
        default: ;
      endcase
    end
  end

  rtc_divider #(
    .DIV_W   (DIV_W),
    .RATE_W  (RATE_W),
    .UIP_LEAD(UIP_LEAD)
  ) i_divider (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (run),
    .hold_i   (hold),
    .inhibit_i(ena_q.inhibit),
    .done_i   (upd_done_i),
    .rate_i   (rate_q),
    .per_evt_o(per_evt),
    .upd_evt_o(upd_evt),
    .uip_o    (uip),
    .cnt_o    (cnt)
  );

  assign fl_set = '{pf: per_evt, af: alarm_i, uf: upd_done_i};
  assign fl_en  = '{pf: ena_q.pie, af: ena_q.aie, uf: ena_q.uie};

  rtc_flags i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fl_set),
    .en_i   (fl_en),
    .clr_i  (rd_c),
    .flags_o(flags),
    .irqf_o (irqf)
  );

  rtc_sqw i_sqw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ena_q.sqwe & (rate_q != '0) & ~hold),
    .toggle_i(per_evt),
    .sqw_o   (sqw_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      per_q <= per_evt;
      upd_q <= upd_evt;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTL:  rdata_o = {uip, dv_q, rate_q};
      ADDR_ENA:  rdata_o = ena_q;
      ADDR_STAT: rdata_o = {irqf, flags, 4'b0000};
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o       = irqf;
  assign per_tick_o  = per_q;
  assign upd_start_o = upd_q;
endmodule

// File: rtl/rtc_irq_unit_chk.sv
module rtc_irq_unit_chk #(
  parameter int unsigned DIV_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_c,
  input logic             alarm_i,
  input logic             upd_done_i,
  input logic             per_evt,
  input logic [2:0]       flags,
  input logic [2:0]       fl_en,
  input logic             irq_o,
  input logic             sqwe,
  input logic             sqw_o,
  input logic             upd_start_o,
  input logic             inhibit,
  input logic             hold,
  input logic [DIV_W-1:0] cnt,
  input logic             per_tick_o,
  input logic [3:0]       rate
);
  // R5
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_c && !alarm_i && !upd_done_i && !per_evt) |=> (flags == 3'b000));

  // R6
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(flags & fl_en)) && !rd_c) |=> irq_o);

  // R7
  sqw_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sqwe |=> !sqw_o);

  // R9
  upd_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_start_o |-> !$past(inhibit));

  // R8
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> (cnt == '0));

  // R3
  per_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_tick_o |-> ($past(rate) != 4'd0));
endmodule

bind rtc_irq_unit rtc_irq_unit_chk #(.DIV_W(DIV_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_c       (rd_c),
  .alarm_i    (alarm_i),
  .upd_done_i (upd_done_i),
  .per_evt    (per_evt),
  .flags      (flags),
  .fl_en      (fl_en),
  .irq_o      (irq_o),
  .sqwe       (ena_q.sqwe),
  .sqw_o      (sqw_o),
  .upd_start_o(upd_start_o),
  .inhibit    (ena_q.inhibit),
  .hold       (hold),
  .cnt        (cnt),
  .per_tick_o (per_tick_o),
  .rate       (rate_q)
);

// File: tb/test_rtc_irq_unit.sv
module test_rtc_irq_unit;
  localparam int SEC  = 32768;
  localparam int LEAD = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] addr_i = 2'd3;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic       alarm_i = 1'b0, upd_done_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o, sqw_o, per_tick_o, upd_start_o;

  int n_chk = 0, n_fail = 0, cycles = 0, tick_mode = 0, ph = 0;

  rtc_irq_unit i_rtc_irq_unit (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .alarm_i(alarm_i), .upd_done_i(upd_done_i), .irq_o(irq_o),
    .sqw_o(sqw_o), .per_tick_o(per_tick_o), .upd_start_o(upd_start_o)
  );

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // reference model, stepped on the rising edge from pre-edge inputs
  int         m_cnt;
  logic [6:0] m_a;
  logic [7:0] m_b;
  logic [2:0] m_fl;
  logic       m_irqf, m_sqw, m_uip, m_per, m_upd;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_a = '0; m_b = '0; m_fl = '0;
      m_irqf = 0; m_sqw = 0; m_uip = 0; m_per = 0; m_upd = 0;
    end else begin
      int  code, period;
      bit  running, drst, per, upd, uset, clr;
      code    = m_a[3:0];
      running = (m_a[6:4] == 3'b010);
      drst    = (m_a[6:5] == 2'b11);
      period  = (code == 0) ? 1 : (1 << (code - 1));
      per  = tick_i && running && code != 0 && ((m_cnt % period) == period - 1);
      upd  = tick_i && running && m_cnt == SEC - 1 && !m_b[7];
      uset = tick_i && running && m_cnt == SEC - 1 - LEAD && !m_b[7];
      if (drst) m_cnt = 0;
      else if (running && tick_i) m_cnt = (m_cnt + 1) % SEC;
      clr  = rd_i && addr_i == 2'd2;
      m_fl = clr ? {per, alarm_i, upd_done_i} : (m_fl | {per, alarm_i, upd_done_i});
      m_irqf = (m_irqf && !clr) || ((m_fl & m_b[6:4]) != 0);
      if (!m_b[3] || code == 0 || drst) m_sqw = 0;
      else if (per) m_sqw = ~m_sqw;
      if (uset) m_uip = 1;
      else if (upd_done_i || drst) m_uip = 0;
      m_per = per;
      m_upd = upd;
      if (wr_i && addr_i == 2'd0) m_a = wdata_i[6:0];
      if (wr_i && addr_i == 2'd1) m_b = wdata_i;
    end
  end

  always @(negedge clk) begin
    ph++;
    tick_i = (tick_mode == 1) || (tick_mode == 3 && ph % 3 == 0);
  end

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #2;
    if (rst_ni) begin
      case (addr_i)
        2'd0: chk("R10 ctl read", rdata_o, {m_uip, m_a});
        2'd1: chk("R2 ena read", rdata_o, m_b);
        2'd2: chk("R5 status read", rdata_o, {m_irqf, m_fl, 4'b0});
        default: chk("R2 unused read", rdata_o, 0);
      endcase
      chk("R6 irq", irq_o, m_irqf);
      chk("R7 sqw", sqw_o, m_sqw);
      chk("R3 per_tick", per_tick_o, m_per);
      chk("R9 upd_start", upd_start_o, m_upd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual %0d cycles expected fewer", cycles);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1;
    @(negedge clk); wr_i = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr_i = a; rd_i = 1;
    #2 d = rdata_o;
    @(negedge clk); rd_i = 0;
  endtask

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1
    rd_reg(2'd0, v); chk("R1 ctl reset", v, 8'h00);
    rd_reg(2'd1, v); chk("R1 ena reset", v, 8'h00);
    rd_reg(2'd2, v); chk("R1 status reset", v, 8'h00);
    chk("R1 irq reset", irq_o, 0);
    chk("R1 sqw reset", sqw_o, 0);
    // R2
    wr_reg(2'd0, 8'hFF); rd_reg(2'd0, v); chk("R2 ctl bit7 read-only", v, 8'h7F);
    wr_reg(2'd1, 8'h5A); rd_reg(2'd1, v); chk("R2 ena write", v, 8'h5A);
    wr_reg(2'd2, 8'hFF); rd_reg(2'd2, v); chk("R2 status write ignored", v, 8'h00);
    // R3 code 1, periodic enable and square wave
    wr_reg(2'd1, 8'h48);
    wr_reg(2'd0, 8'h21);
    tick_mode = 1;
    repeat (16) @(negedge clk);
    rd_reg(2'd2, v); chk("R4 periodic flag with irq", v, 8'hC0);
    wr_reg(2'd0, 8'h23);
    repeat (200) @(negedge clk);
    rd_reg(2'd2, v);
    tick_mode = 3;
    wr_reg(2'd0, 8'h26);
    repeat (400) @(negedge clk);
    rd_reg(2'd2, v);
    // R4 alarm
    tick_mode = 0;
    wr_reg(2'd1, 8'h20);
    rd_reg(2'd2, v);
    @(negedge clk); alarm_i = 1;
    @(negedge clk); alarm_i = 0;
    rd_reg(2'd2, v); chk("R4 alarm flag", v, 8'hA0);
    // R5 event in the clearing cycle is kept
    @(negedge clk); addr_i = 2'd2; rd_i = 1; alarm_i = 1;
    #2 chk("R5 read before event", rdata_o, 8'h00);
    @(negedge clk); rd_i = 0; alarm_i = 0;
    rd_reg(2'd2, v); chk("R5 coincident event kept", v, 8'hA0);
    // R4 update-finished flag
    wr_reg(2'd1, 8'h10);
    @(negedge clk); upd_done_i = 1;
    @(negedge clk); upd_done_i = 0;
    rd_reg(2'd2, v); chk("R4 update flag", v, 8'h90);
    // R6 flag without enable leaves bit 7 clear
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'h21);
    tick_mode = 1;
    repeat (5) @(negedge clk);
    rd_reg(2'd2, v); chk("R6 gated summary", v, 8'h40);
    // R8 divider reset
    wr_reg(2'd1, 8'h08);
    wr_reg(2'd0, 8'h66);
    rd_reg(2'd2, v);
    repeat (300) @(negedge clk);
    rd_reg(2'd2, v); chk("R8 no events in reset", v, 8'h00);
    chk("R7 sqw low in reset", sqw_o, 0);
    // R8 frozen divider
    wr_reg(2'd0, 8'h06);
    repeat (50) @(negedge clk);
    rd_reg(2'd2, v); chk("R8 frozen divider", v, 8'h00);
    wr_reg(2'd0, 8'h66);
    // R9 first update one second after release
    wr_reg(2'd1, 8'h18);
    wr_reg(2'd0, 8'h2F);
    n = 0;
    do begin
      @(negedge clk); #3; n++;
    end while (!upd_start_o && n < SEC + 50);
    chk("R9 first update delay", n, SEC);
    rd_reg(2'd0, v); chk("R10 uip high", v, 8'hAF);
    @(negedge clk); upd_done_i = 1;
    @(negedge clk); upd_done_i = 0;
    rd_reg(2'd0, v); chk("R10 uip cleared", v, 8'h2F);
    rd_reg(2'd2, v);
    // R9 inhibit
    wr_reg(2'd1, 8'h98);
    n = 0;
    for (int i = 0; i < SEC + 100; i++) begin
      @(negedge clk); #3;
      if (upd_start_o) n++;
    end
    chk("R9 inhibited updates", n, 0);
    rd_reg(2'd0, v); chk("R10 no uip while inhibited", v[7], 0);
    tick_mode = 0;
    repeat (4) @(negedge clk);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule